// File: doc/BRIEF.md
# Pixel Shift and Mask Assist Unit

This register-mapped helper speeds up software drawing into a framebuffer that packs eight 4-bit pixels into each 32-bit word. Drawing a bitmap at a horizontal position that is not a multiple of eight pixels means splitting every source word across two destination words. Software writes the source word, then writes the horizontal coordinate as a shift count. Three values can then be read back: the word moved right by whole pixels, the pixels pushed out on the right realigned to the top of a second word, and a transparency mask of the moved word. A separate mask generator register turns any stored pixel word into a mask with one nibble per pixel, where a nibble is all ones when its pixel is nonzero.

Pixel order is big-endian: pixel 0, the leftmost, sits in bits 31-28 and pixel 7 sits in bits 3-0. The bus is word-addressed on a 7-bit byte offset. Write data is taken on the clock edge where the write enable is high. Read data is registered and is valid one clock after the read enable. A small state machine records whether the source is raw or shifted. State ST_RAW is entered on reset and on a source write (transition T_LOAD). State ST_SHIFTED is entered on a count write (transition T_SHIFT). Writing the count again in ST_SHIFTED re-shifts the original source and does not build on the previous result.

Top module: `pxa_shift_unit`

## Requirements
- R1: After a synchronous active-high reset, a read of any register returns 0x00000000.
- R2: A write to offset 0x18 stores the source word. In state ST_RAW, a read of 0x18 returns the source unchanged and a read of 0x24 returns zero.
- R3: A write to offset 0x1C sets the count c. A read of 0x18 then returns the source shifted right by 4*c bits, with zero pixels filled in at the left.
- R4: Only bits 2-0 of the value written to 0x1C are used. Bits 31-3 have no effect on any result.
- R5: A read of 0x24 returns the c rightmost source pixels placed in the c leftmost positions, with every other bit zero. For c = 2, source bits 7-0 appear in bits 31-24.
- R6: A read of 0x20 returns the nibble mask of the shifted word: a nibble reads 0xF when its pixel is nonzero and 0x0 when its pixel is zero.
- R7: A write to 0x28 stores a word. A read of 0x28 returns the nibble mask of that stored word (for example 0x1234ABC0 gives 0xFFFFFFF0).
- R8: A write to 0x18 resets the count to zero, even when a count was written earlier.
- R9: Read data appears one clock after the read enable and holds its value while the read enable is low. A read in the cycle after a count write already reflects the new count.
- R10: A read of the count register 0x1C, or of any offset other than 0x18, 0x20, 0x24 and 0x28, returns zero.
- R11: Writes to 0x28 do not change the shifter results, and writes to 0x18 or 0x1C do not change the 0x28 result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| we | input | 1 | Write enable |
| re | input | 1 | Read enable |
| addr | input | 7 | Byte offset within the controller slot |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
The hardest case to reach is a count written while the unit is already in ST_SHIFTED, followed by a source write that must clear the count. A fault that makes shifts build on each other, or that keeps a stale count, stays hidden under a plain write-then-read sequence. The stimulus writes two different counts in a row, each with high garbage bits, and checks that the second result comes from the original source. It then writes a new source and checks both that the shift is gone and that the spill word reads zero.

// File: rtl/pxa_pkg.sv
package pxa_pkg;
    localparam int OFF_SRC   = 'h18;
    localparam int OFF_CNT   = 'h1C;
    localparam int OFF_SMASK = 'h20;
    localparam int OFF_SPILL = 'h24;
    localparam int OFF_MGEN  = 'h28;

    typedef enum logic {
        ST_RAW,
        ST_SHIFTED
    } shf_state_e;
endpackage

// File: rtl/pxa_nibble_shifter.sv
module pxa_nibble_shifter #(
    parameter int PIX_W = 4,
    parameter int NPIX  = 8,
    localparam int DW   = PIX_W * NPIX,
    localparam int CW   = $clog2(NPIX)
) (
    input  logic [DW-1:0] src,
    input  logic [CW-1:0] cnt,
    output logic [DW-1:0] shifted,
    output logic [DW-1:0] spill
);
    // Pixel p counts from the left; its lowest bit is at (NPIX-1-p)*PIX_W.
    always_comb begin
        shifted = '0;
        spill   = '0;
        for (int p = 0; p < NPIX; p++) begin
            if (p >= int'(cnt))
                shifted[(NPIX-1-p)*PIX_W +: PIX_W] = src[(NPIX-1-(p-int'(cnt)))*PIX_W +: PIX_W];
            else
                spill[(NPIX-1-p)*PIX_W +: PIX_W] = src[(int'(cnt)-1-p)*PIX_W +: PIX_W];
        end
    end
endmodule

// File: rtl/pxa_nibble_mask.sv
module pxa_nibble_mask #(
    parameter int PIX_W = 4,
    parameter int NPIX  = 8,
    localparam int DW   = PIX_W * NPIX
) (
    input  logic [DW-1:0] pix,
    output logic [DW-1:0] mask
);
    for (genvar i = 0; i < NPIX; i++) begin : g_pix
        assign mask[i*PIX_W +: PIX_W] = {PIX_W{|pix[i*PIX_W +: PIX_W]}};
    end
endmodule

// File: rtl/pxa_shift_unit.sv
module pxa_shift_unit
    import pxa_pkg::*;
#(
    parameter int PIX_W  = 4,
    parameter int NPIX   = 8,
    parameter int ADDR_W = 7,
    localparam int DW    = PIX_W * NPIX,
    localparam int CW    = $clog2(NPIX)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata
);
    shf_state_e    state_q, state_d;
    logic [DW-1:0] src_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] gen_q;
    logic [DW-1:0] shifted, spill, smask, gmask;
    logic          wr_src, wr_cnt, wr_gen;

    assign wr_src = we && (addr == ADDR_W'(OFF_SRC));
    assign wr_cnt = we && (addr == ADDR_W'(OFF_CNT));
    assign wr_gen = we && (addr == ADDR_W'(OFF_MGEN));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RAW:     if (wr_cnt) state_d = ST_SHIFTED;          // T_SHIFT
            ST_SHIFTED: if (wr_src && !wr_cnt) state_d = ST_RAW;   // T_LOAD
        endcase
    end

    // State register and stored words
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RAW;
            src_q   <= '0;
            cnt_q   <= '0;
            gen_q   <= '0;
        end else begin
            state_q <= state_d;
            if (wr_src) begin
                src_q <= wdata;
                cnt_q <= '0;
            end
            if (wr_cnt) cnt_q <= wdata[CW-1:0];
            if (wr_gen) gen_q <= wdata;
        end
    end

    pxa_nibble_shifter #(.PIX_W(PIX_W), .NPIX(NPIX)) i_shift (
        .src(src_q), .cnt(cnt_q), .shifted(shifted), .spill(spill)
    );
    pxa_nibble_mask #(.PIX_W(PIX_W), .NPIX(NPIX)) i_smask (
        .pix(shifted), .mask(smask)
    );
    pxa_nibble_mask #(.PIX_W(PIX_W), .NPIX(NPIX)) i_gmask (
        .pix(gen_q), .mask(gmask)
    );

    // Output process: registered read data
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            if (addr == ADDR_W'(OFF_SRC))        rdata <= shifted;
            else if (addr == ADDR_W'(OFF_SMASK)) rdata <= smask;
            else if (addr == ADDR_W'(OFF_SPILL)) rdata <= spill;
            else if (addr == ADDR_W'(OFF_MGEN))  rdata <= gmask;
            else                                 rdata <= '0;
        end
    end
endmodule

// File: rtl/pxa_shift_unit_chk.sv
module pxa_shift_unit_chk
    import pxa_pkg::*;
#(
    parameter int PIX_W  = 4,
    parameter int NPIX   = 8,
    parameter int ADDR_W = 7,
    localparam int DW    = PIX_W * NPIX,
    localparam int CW    = $clog2(NPIX)
) (
    input logic              clk,
    input logic              rst,
    input logic              we,
    input logic              re,
    input logic [ADDR_W-1:0] addr,
    input logic [DW-1:0]     wdata,
    input logic [DW-1:0]     rdata,
    input logic [CW-1:0]     cnt_q,
    input shf_state_e        state_q,
    input logic [DW-1:0]     shifted,
    input logic [DW-1:0]     spill,
    input logic [DW-1:0]     smask
);
    logic is_mapped;
    assign is_mapped = (addr == ADDR_W'(OFF_SRC)) || (addr == ADDR_W'(OFF_SMASK)) ||
                       (addr == ADDR_W'(OFF_SPILL)) || (addr == ADDR_W'(OFF_MGEN));

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !re |=> $stable(rdata));

    p_count_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (we && addr == ADDR_W'(OFF_SRC) && !(we && addr == ADDR_W'(OFF_CNT))) |=> (cnt_q == '0));

    p_count_low_bits_r4: assert property (@(posedge clk) disable iff (rst)
        (we && addr == ADDR_W'(OFF_CNT)) |=> (cnt_q == $past(wdata[CW-1:0])));

    p_raw_no_spill_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RAW) |-> (spill == '0 && cnt_q == '0));

    p_mask_covers_r6: assert property (@(posedge clk) disable iff (rst)
        ((shifted & ~smask) == '0));

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (re && !is_mapped) |=> (rdata == '0));

    p_no_overlap_r5: assert property (@(posedge clk) disable iff (rst)
        ((shifted | spill) == '0) || ((shifted & spill) == '0) || (cnt_q != '0));
endmodule

bind pxa_shift_unit pxa_shift_unit_chk #(.PIX_W(PIX_W), .NPIX(NPIX), .ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst(rst), .we(we), .re(re), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cnt_q(cnt_q), .state_q(state_q), .shifted(shifted),
    .spill(spill), .smask(smask)
);

// File: tb/test_pxa_shift_unit.sv
module test_pxa_shift_unit;
    localparam logic [6:0] A_SRC = 7'h18, A_CNT = 7'h1C, A_SMASK = 7'h20,
                           A_SPILL = 7'h24, A_MGEN = 7'h28;

    logic        clk = 0;
    logic        rst = 1;
    logic        we = 0, re = 0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    int          n_checks = 0, n_errors = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    pxa_shift_unit i_pxa_shift_unit (
        .clk(clk), .rst(rst), .we(we), .re(re), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [31:0] exp_mask(input logic [31:0] v);
        logic [31:0] m = '0;
        for (int i = 0; i < 8; i++) m[i*4 +: 4] = (v[i*4 +: 4] != 0) ? 4'hF : 4'h0;
        return m;
    endfunction
    function automatic logic [31:0] exp_shift(input logic [31:0] v, input int c);
        return v >> (4 * c);
    endfunction
    function automatic logic [31:0] exp_spill(input logic [31:0] v, input int c);
        return (c == 0) ? 32'h0 : v << (32 - 4 * c);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk); we = 1; addr = a; wdata = d;
        @(negedge clk); we = 0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk); re = 1; addr = a;
        @(negedge clk); re = 0; d = rdata;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(A_SRC, d);   check("R1 shifter", d, 0);
        rd(A_SMASK, d); check("R1 smask", d, 0);
        rd(A_SPILL, d); check("R1 spill", d, 0);
        rd(A_MGEN, d);  check("R1 mgen", d, 0);
    endtask

    task automatic t_load;
        logic [31:0] d;
        wr(A_SRC, 32'h1234ABC0);
        rd(A_SRC, d);   check("R2 raw", d, 32'h1234ABC0);
        rd(A_SPILL, d); check("R2 spill zero", d, 0);
    endtask

    task automatic t_shift_all;
        logic [31:0] d;
        logic [31:0] s = 32'h9A0B00C1;
        wr(A_SRC, s);
        for (int c = 0; c < 8; c++) begin
            wr(A_CNT, 32'(c));
            rd(A_SRC, d);   check("R3 shifted", d, exp_shift(s, c));
            rd(A_SPILL, d); check("R5 spill", d, exp_spill(s, c));
            rd(A_SMASK, d); check("R6 smask", d, exp_mask(exp_shift(s, c)));
        end
    endtask

    task automatic t_spill_two;
        logic [31:0] d;
        wr(A_SRC, 32'hFEDCBA98);
        wr(A_CNT, 32'd2);
        rd(A_SPILL, d); check("R5 count two", d, 32'h98000000);
    endtask

    task automatic t_high_bits_and_reshift;
        logic [31:0] d;
        logic [31:0] s = 32'h12345678;
        wr(A_SRC, s);
        wr(A_CNT, 32'hFFFF_FF03);       // low bits 3
        rd(A_SRC, d); check("R4 high bits ignored", d, exp_shift(s, 3));
        wr(A_CNT, 32'd645);             // 645 = ...101 -> 5, from original source
        rd(A_SRC, d);   check("R4 coordinate", d, exp_shift(s, 5));
        rd(A_SPILL, d); check("R5 reshift spill", d, exp_spill(s, 5));
        wr(A_SRC, 32'h0F0F0F0F);
        rd(A_SRC, d);   check("R8 count cleared", d, 32'h0F0F0F0F);
        rd(A_SPILL, d); check("R8 spill cleared", d, 0);
    endtask

    task automatic t_mgen;
        logic [31:0] d;
        wr(A_MGEN, 32'h0407000F); rd(A_MGEN, d); check("R7 example a", d, 32'h0F0F000F);
        wr(A_MGEN, 32'h1234ABC0); rd(A_MGEN, d); check("R7 example b", d, 32'hFFFFFFF0);
        wr(A_MGEN, 32'h00000001); rd(A_MGEN, d); check("R7 example c", d, 32'h0000000F);
    endtask

    task automatic t_isolation;
        logic [31:0] d;
        wr(A_SRC, 32'hA0000005);
        wr(A_CNT, 32'd1);
        wr(A_MGEN, 32'h00F00000);
        rd(A_SRC, d);  check("R11 shifter untouched", d, 32'h0A000000);
        wr(A_SRC, 32'h11111111);
        wr(A_CNT, 32'd4);
        rd(A_MGEN, d); check("R11 mgen untouched", d, 32'h00F00000);
    endtask

    task automatic t_latency_and_unmapped;
        logic [31:0] d;
        wr(A_SRC, 32'h87654321);
        // count write followed at once by a read in the next cycle
        @(negedge clk); we = 1; addr = A_CNT; wdata = 32'd1;
        @(negedge clk); we = 0; re = 1; addr = A_SRC;
        @(negedge clk); re = 0; d = rdata;
        check("R9 read after count", d, 32'h08765432);
        wr(A_CNT, 32'd6);               // changes result while re is low
        repeat (2) @(negedge clk);
        check("R9 hold", rdata, 32'h08765432);
        rd(A_CNT, d);  check("R10 count reads zero", d, 0);
        rd(7'h00, d);  check("R10 unmapped 00", d, 0);
        rd(7'h19, d);  check("R10 unaligned", d, 0);
        rd(7'h7C, d);  check("R10 unmapped 7C", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_load();
        t_shift_all();
        t_spill_two();
        t_high_bits_and_reshift();
        t_mgen();
        t_isolation();
        t_latency_and_unmapped();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule